// File: doc/BRIEF.md
# Pre/Post-Trigger Capture Controller

This block sits between a sampled multi-channel input word and an external sample memory. Once armed, it stores one 16-bit sample word at each sample-enable tick into the current memory bank. The write address runs round the bank as a ring, so the newest samples before a trigger are always present. Which samples it keeps is set by two separate counts: the samples wanted before the trigger and the samples wanted after it. A programmable divider of the fast system clock sets how often a sample is taken.

Capture starts in a pre-fill phase. During pre-fill the trigger input is masked until the requested number of pre-trigger words has been stored. After that the controller keeps writing round the ring and watches the trigger input at each sample tick. The word taken on the tick where the trigger is seen is written at the trigger address, and that address is latched. A post-trigger countdown then stores the requested number of further words and stops.

When a capture ends, the controller pulses a completion flag and reports the bank it filled. It then switches to the other bank, so a reader can drain the finished bank while the next capture runs. A reader marks a bank as in use through a per-bank busy input. A capture that is due to start in a bank still marked in use waits in idle until the reader releases that bank.

Top module: `trig_capture_ctrl`

## Requirements
- R1: After reset, `mem_we` and `done` are 0, and the first capture after reset fills bank 0.
- R2: While capturing, one word is written every `cfg_div`+1 clock cycles, and `cfg_div` is held steady during a capture. Two words written in a row therefore carry `smp_in` values taken `cfg_div`+1 cycles apart.
- R3: The trigger input has no effect until the effective pre-trigger count of words has been stored. A trigger held high from the start of a capture takes effect on the first sample after pre-fill, so `trig_addr` equals the effective pre-trigger count.
- R4: Every capture starts writing at address 0, and the address advances by one for each write, wrapping modulo the bank depth 2^`ADDR_W`.
- R5: `trig_addr` is the address of the word taken on the first eligible sample tick at which `trig_in` is 1. That word is the trigger sample.
- R6: After the trigger sample, exactly the effective post-trigger count of further words is written. No write then follows until the next capture starts.
- R7: The effective pre-trigger count is min(`cfg_pre`, D-1), where D is the bank depth. The effective post-trigger count is min(`cfg_post`, D-1-pre). The window, made of the pre-trigger words, the trigger sample and the post-trigger words, therefore never exceeds the bank.
- R8: At the end of a capture, `done` is 1 for exactly one cycle, and `done_bank` names the bank just filled. The next capture uses the other bank.
- R9: An `arm` pulse is remembered. A capture whose bank has its `bank_busy` bit set stays idle and writes nothing until that bit clears, and then it runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_div | input | DIV_W | Sample-enable divider; one sample every cfg_div+1 clocks |
| cfg_pre | input | ADDR_W+1 | Requested pre-trigger word count |
| cfg_post | input | ADDR_W+1 | Requested post-trigger word count |
| arm | input | 1 | Capture request pulse |
| trig_in | input | 1 | Trigger condition, sampled on sample ticks |
| smp_in | input | DATA_W | Sample word for all channels |
| bank_busy | input | 2 | Per-bank flag set by the reader while draining |
| mem_we | output | 1 | Memory write strobe |
| mem_bank | output | 1 | Bank of the current write |
| mem_addr | output | ADDR_W | Word address within the bank |
| mem_wdata | output | DATA_W | Word to write |
| trig_addr | output | ADDR_W | Address of the latest trigger sample |
| done | output | 1 | One-cycle capture-complete pulse |
| done_bank | output | 1 | Bank that the finished capture filled |

## Verification
The bench builds the controller with `ADDR_W` set to 4, so each bank is 16 words deep. At that depth a trigger that arrives late makes the ring wrap within a few dozen samples. Both clamp limits can then be reached with small counts, and the window can be checked word by word against a bank model kept in the bench. The bench drives a free-running cycle count as `smp_in`, so each stored word shows when it was sampled. This exposes the divider spacing and the exact trigger sample. Dividers of 0, 1 and 2 cover the full-rate case and two reduced rates.

// File: rtl/cap_pkg.sv
package cap_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_WAIT,
        ST_POST,
        ST_DONE
    } cap_state_e;
endpackage

// File: rtl/cap_rate_div.sv
module cap_rate_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = run && (cnt_q == div);
        cnt_d = cnt_q + DIV_W'(1);
        if (!run || tick) begin
            cnt_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/cap_window_clamp.sv
module cap_window_clamp #(
    parameter int ADDR_W = 20
) (
    input  logic [ADDR_W:0] req_pre,
    input  logic [ADDR_W:0] req_post,
    output logic [ADDR_W:0] pre_eff,
    output logic [ADDR_W:0] post_eff
);
    localparam int CW = ADDR_W + 1;
    localparam logic [CW-1:0] LIMIT = CW'((1 << ADDR_W) - 1);

    logic [CW-1:0] room;

    always_comb begin
        pre_eff  = (req_pre > LIMIT) ? LIMIT : req_pre;
        room     = LIMIT - pre_eff;
        post_eff = (req_post > room) ? room : req_post;
    end
endmodule

// File: rtl/trig_capture_ctrl.sv
module trig_capture_ctrl #(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic [ADDR_W:0]   cfg_pre,
    input  logic [ADDR_W:0]   cfg_post,
    input  logic              arm,
    input  logic              trig_in,
    input  logic [DATA_W-1:0] smp_in,
    input  logic [1:0]        bank_busy,
    output logic              mem_we,
    output logic              mem_bank,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [ADDR_W-1:0] trig_addr,
    output logic              done,
    output logic              done_bank
);
    import cap_pkg::*;

    localparam int CW = ADDR_W + 1;

    typedef struct packed {
        cap_state_e          st;
        logic                pend;
        logic                bank;
        logic [ADDR_W-1:0]   addr;
        logic [CW-1:0]       cnt;
        logic [CW-1:0]       pre;
        logic [CW-1:0]       post;
        logic                we;
        logic                wbank;
        logic [ADDR_W-1:0]   waddr;
        logic [DATA_W-1:0]   wdata;
        logic [ADDR_W-1:0]   taddr;
        logic                done;
        logic                dbank;
    } regs_t;

    regs_t         r_d, r_q;
    logic          tick;
    logic          run;
    logic [CW-1:0] pre_eff, post_eff;
    cap_state_e    st_q;
    logic          bank_q;

    assign st_q   = r_q.st;
    assign bank_q = r_q.bank;
    assign run    = (r_q.st == ST_PRE) || (r_q.st == ST_WAIT) || (r_q.st == ST_POST);

    cap_rate_div #(.DIV_W(DIV_W)) i_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .div   (cfg_div),
        .tick  (tick)
    );

    cap_window_clamp #(.ADDR_W(ADDR_W)) i_clamp (
        .req_pre  (cfg_pre),
        .req_post (cfg_post),
        .pre_eff  (pre_eff),
        .post_eff (post_eff)
    );

    always_comb begin
        r_d      = r_q;
        r_d.we   = 1'b0;
        r_d.done = 1'b0;
        if (arm) begin
            r_d.pend = 1'b1;
        end
        if (run && tick) begin
            r_d.we    = 1'b1;
            r_d.wbank = r_q.bank;
            r_d.waddr = r_q.addr;
            r_d.wdata = smp_in;
            r_d.addr  = r_q.addr + ADDR_W'(1);
        end
        unique case (r_q.st)
            ST_IDLE: begin
                if ((arm || r_q.pend) && !bank_busy[r_q.bank]) begin
                    r_d.pend = 1'b0;
                    r_d.pre  = pre_eff;
                    r_d.post = post_eff;
                    r_d.addr = '0;
                    r_d.cnt  = '0;
                    r_d.st   = (pre_eff == '0) ? ST_WAIT : ST_PRE;
                end
            end
            ST_PRE: begin
                if (tick) begin
                    r_d.cnt = r_q.cnt + CW'(1);
                    if (r_q.cnt + CW'(1) == r_q.pre) begin
                        r_d.st = ST_WAIT;
                    end
                end
            end
            ST_WAIT: begin
                if (tick && trig_in) begin
                    r_d.taddr = r_q.addr;
                    r_d.cnt   = '0;
                    r_d.st    = (r_q.post == '0) ? ST_DONE : ST_POST;
                end
            end
            ST_POST: begin
                if (tick) begin
                    r_d.cnt = r_q.cnt + CW'(1);
                    if (r_q.cnt + CW'(1) == r_q.post) begin
                        r_d.st = ST_DONE;
                    end
                end
            end
            ST_DONE: begin
                r_d.done  = 1'b1;
                r_d.dbank = r_q.bank;
                r_d.bank  = ~r_q.bank;
                r_d.st    = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign mem_we    = r_q.we;
    assign mem_bank  = r_q.wbank;
    assign mem_addr  = r_q.waddr;
    assign mem_wdata = r_q.wdata;
    assign trig_addr = r_q.taddr;
    assign done      = r_q.done;
    assign done_bank = r_q.dbank;
endmodule

// File: rtl/cap_checker.sv
module cap_checker #(
    parameter int DIV_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input cap_pkg::cap_state_e st,
    input logic              bank,
    input logic [1:0]        bank_busy,
    input logic [DIV_W-1:0]  cfg_div,
    input logic              mem_we,
    input logic              done,
    input logic              done_bank
);
    import cap_pkg::*;

    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE || st == ST_DONE) |=> !mem_we) else $error("idle write"); // R6

    AST_DIV_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && cfg_div != '0 && $stable(cfg_div)) |=> !mem_we) else $error("write gap"); // R2

    AST_PRE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PRE) |=> (st == ST_PRE || st == ST_WAIT)) else $error("pre mask"); // R3

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done) else $error("done width"); // R8

    AST_BANK_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (bank != done_bank)) else $error("bank swap"); // R8

    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && bank_busy[bank]) |=> (st == ST_IDLE)) else $error("busy start"); // R9
endmodule

bind trig_capture_ctrl cap_checker #(.DIV_W(DIV_W)) i_cap_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .st        (st_q),
    .bank      (bank_q),
    .bank_busy (bank_busy),
    .cfg_div   (cfg_div),
    .mem_we    (mem_we),
    .done      (done),
    .done_bank (done_bank)
);

// File: tb/test_trig_capture_ctrl.sv
module test_trig_capture_ctrl;
    localparam int AW    = 4;
    localparam int DW    = 16;
    localparam int DVW   = 4;
    localparam int DEPTH = 1 << AW;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [DVW-1:0] cfg_div = '0;
    logic [AW:0]    cfg_pre = '0;
    logic [AW:0]    cfg_post = '0;
    logic           arm = 1'b0;
    logic           trig_in = 1'b0;
    logic [DW-1:0]  smp_in;
    logic [1:0]     bank_busy = 2'b00;
    logic           mem_we, mem_bank, done, done_bank;
    logic [AW-1:0]  mem_addr, trig_addr;
    logic [DW-1:0]  mem_wdata;

    int             cyc = 0;
    int             wr_cnt = 0;
    logic [DW-1:0]  mem [0:1][0:DEPTH-1];
    int             errors = 0;
    int             checks = 0;
    bit             exp_bank = 1'b0;
    bit             finished = 1'b0;

    assign smp_in = cyc[DW-1:0];

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_we) begin
            mem[mem_bank][mem_addr] <= mem_wdata;
            wr_cnt <= wr_cnt + 1;
        end
    end

    trig_capture_ctrl #(.ADDR_W(AW), .DATA_W(DW), .DIV_W(DVW)) i_trig_capture_ctrl (
        .clk, .rst_n, .cfg_div, .cfg_pre, .cfg_post, .arm, .trig_in, .smp_in,
        .bank_busy, .mem_we, .mem_bank, .mem_addr, .mem_wdata, .trig_addr,
        .done, .done_bank
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int eff_pre(input int p);
        return (p > DEPTH - 1) ? DEPTH - 1 : p;
    endfunction

    function automatic int eff_post(input int p, input int q);
        int room = DEPTH - 1 - eff_pre(p);
        return (q > room) ? room : q;
    endfunction

    task automatic wait_done(output bit seen);
        seen = 1'b0;
        for (int i = 0; i < 5000 && !seen; i++) begin
            @(negedge clk);
            if (done) seen = 1'b1;
        end
    endtask

    // Checks one finished window: count, trigger address, spacing, trigger sample.
    task automatic check_window(input string tag, input int base, input int pe, input int qe,
                                input int div, input int t_raise, input bit late);
        int  n = wr_cnt - base;
        int  ta = int'(trig_addr);
        bit  sp_ok = 1'b1;
        int  bad = 0;
        logic [DW-1:0] tv;
        chk(done_bank == exp_bank, {tag, " R8 done_bank"}, int'(done_bank), int'(exp_bank));
        chk(ta == (n - qe - 1) % DEPTH, {tag, " R5 R4 trig_addr vs writes"}, ta, (n - qe - 1) % DEPTH);
        if (!late) begin
            chk(n == pe + 1 + qe, {tag, " R6 write count"}, n, pe + 1 + qe);
            chk(ta == pe, {tag, " R3 trigger after pre-fill"}, ta, pe);
        end else begin
            chk(n > DEPTH, {tag, " R4 ring wrapped"}, n, DEPTH + 1);
        end
        for (int k = 0; k < pe + qe; k++) begin
            int a = (ta - pe + k + DEPTH) % DEPTH;
            int b = (a + 1) % DEPTH;
            if (16'(mem[exp_bank][b] - mem[exp_bank][a]) != 16'(div + 1)) begin
                sp_ok = 1'b0;
                bad = int'(16'(mem[exp_bank][b] - mem[exp_bank][a]));
            end
        end
        chk(sp_ok, {tag, " R2 sample spacing"}, bad, div + 1);
        tv = mem[exp_bank][ta];
        chk(int'(tv) >= t_raise, {tag, " R5 trigger sample not early"}, int'(tv), t_raise);
        if (late) begin
            chk(int'(tv) < t_raise + div + 1, {tag, " R5 trigger sample first eligible"},
                int'(tv), t_raise);
        end
    endtask

    task automatic run_cap(input string tag, input int pre, input int post, input int div,
                           input int delay, input bit late);
        int pe = eff_pre(pre);
        int qe = eff_post(pre, post);
        int base, t_raise, after;
        bit seen;
        @(negedge clk);
        cfg_pre  = (AW+1)'(pre);
        cfg_post = (AW+1)'(post);
        cfg_div  = DVW'(div);
        base     = wr_cnt;
        arm      = 1'b1;
        @(negedge clk);
        arm      = 1'b0;
        repeat (delay) @(negedge clk);
        t_raise  = cyc;
        trig_in  = 1'b1;
        wait_done(seen);
        chk(seen, {tag, " R8 done seen"}, int'(seen), 1);
        trig_in  = 1'b0;
        check_window(tag, base, pe, qe, div, t_raise, late);
        @(negedge clk);
        chk(!done, {tag, " R8 done one cycle"}, int'(done), 0);
        after = wr_cnt;
        repeat (20) @(negedge clk);
        chk(wr_cnt == after, {tag, " R6 stopped"}, wr_cnt - after, 0);
        exp_bank = ~exp_bank;
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(!mem_we, "R1 mem_we at reset", int'(mem_we), 0);
        chk(!done, "R1 done at reset", int'(done), 0);
        chk(exp_bank == 1'b0, "R1 first bank", int'(exp_bank), 0);
    endtask

    task automatic t_busy;
        int base;
        bit seen;
        @(negedge clk);
        cfg_pre   = 5'd2;
        cfg_post  = 5'd3;
        cfg_div   = '0;
        bank_busy = 2'b00;
        bank_busy[exp_bank] = 1'b1;
        base      = wr_cnt;
        arm       = 1'b1;
        trig_in   = 1'b1;
        @(negedge clk);
        arm       = 1'b0;
        repeat (30) @(negedge clk);
        chk(wr_cnt == base, "R9 no write while bank busy", wr_cnt - base, 0);
        bank_busy = 2'b00;
        wait_done(seen);
        chk(seen, "R9 capture runs after release", int'(seen), 1);
        trig_in = 1'b0;
        chk(done_bank == exp_bank, "R9 bank after release", int'(done_bank), int'(exp_bank));
        chk(wr_cnt - base == 6, "R9 write count after release", wr_cnt - base, 6);
        chk(trig_addr == AW'(2), "R9 R3 trig_addr", int'(trig_addr), 2);
        exp_bank = ~exp_bank;
        repeat (5) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        run_cap("early d0", 4, 5, 0, 0, 1'b0);
        run_cap("early d2", 3, 2, 2, 0, 1'b0);
        run_cap("late wrap d1", 3, 4, 1, 60, 1'b1);
        run_cap("no pre", 0, 4, 0, 0, 1'b0);
        run_cap("R7 clamp both", 20, 20, 0, 0, 1'b0);
        run_cap("R7 clamp post", 10, 10, 1, 0, 1'b0);
        run_cap("late d0", 6, 3, 0, 40, 1'b1);
        t_busy();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule